// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block sits between a transaction-level I2C target front end and an SMBus device model. The front end hands it one operation per cycle: a start in the send direction, a start in the receive direction, a stop, a NACK from the controller, an incoming data byte, or a request for the next byte to return. The sequencer keeps each written byte in a small buffer. It works out which SMBus operation the controller meant only when the transaction turns around or ends. A write with no bytes is a quick command, a write with one byte is a send byte, and a write with several bytes is a command write. A read that follows a write of at least one byte is a command read. A read with no write before it is a receive byte.

Decoded operations go to the device side as single-cycle strobes that are valid in the same cycle as the operation that causes them. The device answers read requests through a combinational data input. The sequencer registers the answer and returns it to the front end one cycle later. The device reads the written bytes through an indexed read port into the buffer. Any event order that SMBus does not allow puts the sequencer in a confused mode, and only a stop takes it out.

Mode names: IDLE, WDATA (write data), RXBYTE (receive byte), RDATA (read data), DONE and CONF (confused). Transitions: IDLE to WDATA on start-send; IDLE to RXBYTE on start-receive; WDATA to RDATA on start-receive with at least one byte buffered; RXBYTE to DONE on a byte request; RDATA to DONE on NACK; any mode to IDLE on stop; all other disallowed events to CONF.

Top module: `smb_target_seq`

## Requirements
- R1: After reset, `mode` is IDLE, `rsp_valid` and `ovf` are 0, and no device strobe is active. The modes are encoded on `mode` as IDLE=0, WDATA=1, RXBYTE=2, RDATA=3, DONE=4, CONF=5. `mode` shows the result of an operation in the cycle after that operation.
- R2: An operation is taken when `op_valid` is 1. `op_code` is encoded as start-send=0, start-receive=1, stop=2, NACK=3, data byte=4, byte request=5, and codes 6 and 7 have no effect. In IDLE, start-send goes to WDATA and start-receive goes to RXBYTE. A start-send in any other mode goes to CONF.
- R3: A stop in WDATA with no buffered bytes raises `dev_quick` in that cycle, with `dev_quick_rd`=0.
- R4: A stop in WDATA with exactly one buffered byte raises `dev_send` in that cycle, and `dev_code` carries that byte.
- R5: A stop in WDATA with n>1 buffered bytes raises `dev_write` in that cycle. `dev_code` carries the first byte and `dev_wr_len` is n-1. Entry k of the buffer read port (`dev_buf_idx`=k gives `dev_buf_data`) holds the k-th byte written, counting from 0, and it stays readable after the stop.
- R6: A stop in RXBYTE raises `dev_quick` with `dev_quick_rd`=1. A stop in any mode returns to IDLE and clears the byte count.
- R7: A start-receive in WDATA with no bytes goes to CONF. With one byte, it dispatches nothing and latches that byte as the command. With more than one byte, it raises `dev_write` in that cycle and latches the first byte. In both non-error cases the count and the read index are cleared and the mode becomes RDATA.
- R8: A byte request in RXBYTE raises `dev_recv`. In the next cycle `rsp_valid`=1 and `rsp_data` holds the value `dev_rdata` had in the request cycle. The mode becomes DONE.
- R9: A byte request in RDATA raises `dev_fetch`, with `dev_code` set to the latched command and `dev_fetch_idx` set to the read index, which starts at 0 and then increments. The response is returned as in R8, and the mode stays RDATA.
- R10: A NACK in RDATA goes to DONE, a NACK in DONE changes nothing, and a NACK in any other mode goes to CONF.
- R11: A data byte outside WDATA is ignored. It changes neither the mode nor the count seen by a later dispatch.
- R12: The buffer holds 33 bytes. A byte that arrives while it is full is dropped and sets `ovf`. `ovf` holds until the next start-send taken in IDLE clears it.
- R13: A byte request in IDLE, WDATA, DONE or CONF returns `rsp_data`=0x00 with `rsp_valid`=1 and goes to CONF. In CONF every operation except stop keeps the mode at CONF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 3 | Operation code (see R2) |
| op_data | input | 8 | Byte carried by a data-byte operation |
| dev_buf_idx | input | 6 | Buffer read port index |
| dev_rdata | input | 8 | Byte supplied by the device for a byte request |
| mode | output | 3 | Current mode (see R1) |
| rsp_valid | output | 1 | Response byte valid, one cycle after a request |
| rsp_data | output | 8 | Response byte returned to the front end |
| ovf | output | 1 | Write buffer overflow flag |
| dev_quick | output | 1 | Quick command strobe |
| dev_quick_rd | output | 1 | Direction bit of the quick command (1 = read) |
| dev_send | output | 1 | Send byte strobe |
| dev_write | output | 1 | Command write strobe |
| dev_wr_len | output | 6 | Number of data bytes after the command |
| dev_code | output | 8 | Send byte value, write command, or latched read command |
| dev_recv | output | 1 | Receive byte strobe |
| dev_fetch | output | 1 | Command read strobe for one byte |
| dev_fetch_idx | output | 8 | Index of the byte being fetched |
| dev_buf_data | output | 8 | Buffer byte at `dev_buf_idx` |

## Verification
A wrong mode appears at the port one cycle after the operation that caused it. It then decides which strobe the next stop or request raises, so a missed transition also shows up as a wrong or missing dispatch at the end of the transaction. An error in the byte count shows up at the next stop or turnaround as the wrong operation type or a wrong `dev_wr_len`. A latched command or read index that has gone wrong shows up as the wrong `dev_code` or `dev_fetch_idx` on the next fetch. The reference model is compared against every output on every cycle, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [2:0] {
        M_IDLE   = 3'd0,
        M_WDATA  = 3'd1,
        M_RXBYTE = 3'd2,
        M_RDATA  = 3'd3,
        M_DONE   = 3'd4,
        M_CONF   = 3'd5
    } mode_t;

    typedef enum logic [2:0] {
        OP_START_WR = 3'd0,
        OP_START_RD = 3'd1,
        OP_STOP     = 3'd2,
        OP_NACK     = 3'd3,
        OP_BYTE     = 3'd4,
        OP_RDREQ    = 3'd5
    } op_t;

endpackage

// File: rtl/smbt_wbuf.sv
module smbt_wbuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 33,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          cnt_clr,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [DW-1:0] mem [DEPTH];

    // Storage: each entry is loaded only when it is the next free slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (count == CW'(i)) mem[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (cnt_clr) count <= '0;
        else if (push)    count <= count + CW'(1);
    end

    assign full = (count == CW'(DEPTH));
    assign head = mem[0];

    // Read port: an index beyond the buffer returns zero.
    generate
        if ((1 << AW) > DEPTH) begin : g_guard
            assign rd_data = (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
        end else begin : g_plain
            assign rd_data = mem[rd_idx];
        end
    endgenerate

endmodule

// File: rtl/smbt_rdidx.sv
module smbt_rdidx #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [IW-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + IW'(1);
    end

endmodule

// File: rtl/smbt_ctrl.sv
module smbt_ctrl
    import smbt_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic [DW-1:0] head,
    input  logic [DW-1:0] dev_rdata,
    output mode_t         state,
    output logic          push,
    output logic          cnt_clr,
    output logic          idx_clr,
    output logic          idx_inc,
    output logic          dev_quick,
    output logic          dev_quick_rd,
    output logic          dev_send,
    output logic          dev_write,
    output logic [DW-1:0] cmd_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          ovf
);

    mode_t state_nx;
    logic  cmd_ld;
    logic  ovf_set;
    logic  ovf_clr;
    logic  rsp_ld;
    logic  rsp_zero;
    logic  cnt_zero;
    logic  cnt_one;

    assign cnt_zero = (count == '0);
    assign cnt_one  = (count == CW'(1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nx;
    end

    // Registers carried alongside the mode: latched command, response, overflow.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            ovf       <= 1'b0;
        end else begin
            if (cmd_ld) cmd_q <= head;
            rsp_valid <= rsp_ld;
            rsp_data  <= (rsp_ld && !rsp_zero) ? dev_rdata : '0;
            if (ovf_clr)      ovf <= 1'b0;
            else if (ovf_set) ovf <= 1'b1;
        end
    end

    // Next mode and outputs.
    always_comb begin
        state_nx     = state;
        push         = 1'b0;
        cnt_clr      = 1'b0;
        idx_clr      = 1'b0;
        idx_inc      = 1'b0;
        dev_quick    = 1'b0;
        dev_quick_rd = 1'b0;
        dev_send     = 1'b0;
        dev_write    = 1'b0;
        cmd_ld       = 1'b0;
        ovf_set      = 1'b0;
        ovf_clr      = 1'b0;
        rsp_ld       = 1'b0;
        rsp_zero     = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OP_START_WR: begin
                    if (state == M_IDLE) begin
                        state_nx = M_WDATA;
                        ovf_clr  = 1'b1;
                        cnt_clr  = 1'b1;
                    end else begin
                        state_nx = M_CONF;
                    end
                end
                OP_START_RD: begin
                    unique case (state)
                        M_IDLE: state_nx = M_RXBYTE;
                        M_WDATA: begin
                            if (cnt_zero) begin
                                state_nx = M_CONF;
                            end else begin
                                dev_write = !cnt_one;
                                cmd_ld    = 1'b1;
                                cnt_clr   = 1'b1;
                                idx_clr   = 1'b1;
                                state_nx  = M_RDATA;
                            end
                        end
                        default: state_nx = M_CONF;
                    endcase
                end
                OP_STOP: begin
                    unique case (state)
                        M_WDATA: begin
                            if (cnt_zero)     dev_quick = 1'b1;
                            else if (cnt_one) dev_send  = 1'b1;
                            else              dev_write = 1'b1;
                        end
                        M_RXBYTE: begin
                            dev_quick    = 1'b1;
                            dev_quick_rd = 1'b1;
                        end
                        default: ;
                    endcase
                    cnt_clr  = 1'b1;
                    state_nx = M_IDLE;
                end
                OP_NACK: begin
                    unique case (state)
                        M_RDATA: state_nx = M_DONE;
                        M_DONE:  state_nx = M_DONE;
                        default: state_nx = M_CONF;
                    endcase
                end
                OP_BYTE: begin
                    if (state == M_WDATA) begin
                        if (full) ovf_set = 1'b1;
                        else      push    = 1'b1;
                    end
                end
                OP_RDREQ: begin
                    rsp_ld = 1'b1;
                    unique case (state)
                        M_RXBYTE: state_nx = M_DONE;
                        M_RDATA:  idx_inc  = 1'b1;
                        default: begin
                            rsp_zero = 1'b1;
                            state_nx = M_CONF;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smb_target_seq.sv
module smb_target_seq
    import smbt_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 33,
    parameter int IW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] op_data,
    input  logic [AW-1:0] dev_buf_idx,
    input  logic [DW-1:0] dev_rdata,
    output logic [2:0]    mode,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          ovf,
    output logic          dev_quick,
    output logic          dev_quick_rd,
    output logic          dev_send,
    output logic          dev_write,
    output logic [CW-1:0] dev_wr_len,
    output logic [DW-1:0] dev_code,
    output logic          dev_recv,
    output logic          dev_fetch,
    output logic [IW-1:0] dev_fetch_idx,
    output logic [DW-1:0] dev_buf_data
);

    mode_t         state;
    logic          push;
    logic          cnt_clr;
    logic          idx_clr;
    logic          idx_inc;
    logic [DW-1:0] head;
    logic [CW-1:0] count;
    logic          full;
    logic [DW-1:0] cmd_q;

    smbt_wbuf #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .AW(AW)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (op_data),
        .cnt_clr (cnt_clr),
        .rd_idx  (dev_buf_idx),
        .rd_data (dev_buf_data),
        .head    (head),
        .count   (count),
        .full    (full)
    );

    smbt_rdidx #(.IW(IW)) u_rdidx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx   (dev_fetch_idx)
    );

    smbt_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .count        (count),
        .full         (full),
        .head         (head),
        .dev_rdata    (dev_rdata),
        .state        (state),
        .push         (push),
        .cnt_clr      (cnt_clr),
        .idx_clr      (idx_clr),
        .idx_inc      (idx_inc),
        .dev_quick    (dev_quick),
        .dev_quick_rd (dev_quick_rd),
        .dev_send     (dev_send),
        .dev_write    (dev_write),
        .cmd_q        (cmd_q),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .ovf          (ovf)
    );

    // A request is forwarded to the device only in the two reading modes.
    assign dev_recv   = op_valid && (op_code == OP_RDREQ) && (state == M_RXBYTE);
    assign dev_fetch  = op_valid && (op_code == OP_RDREQ) && (state == M_RDATA);
    assign mode       = state;
    assign dev_wr_len = dev_write ? (count - CW'(1)) : '0;
    assign dev_code   = (dev_send || dev_write) ? head : cmd_q;

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker
    import smbt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [2:0] mode,
    input logic       rsp_valid,
    input logic       ovf,
    input logic       dev_quick,
    input logic       dev_send,
    input logic       dev_write,
    input logic       dev_recv,
    input logic       dev_fetch
);

    logic is_stop;
    logic is_sw;
    assign is_stop = op_valid && (op_code == OP_STOP);
    assign is_sw   = op_valid && (op_code == OP_START_WR);

    a_r2_idle_send: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sw && mode == M_IDLE) |=> (mode == M_WDATA));

    a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |=> (mode == M_IDLE));

    a_r8_recv_done: assert property (@(posedge clk) disable iff (!rst_n)
        dev_recv |=> (mode == M_DONE && rsp_valid));

    a_r5_one_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || !op_valid) |-> $onehot0({dev_quick, dev_send, dev_write, dev_recv, dev_fetch}));

    a_r10_nack_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_NACK && mode == M_RDATA) |=> (mode == M_DONE));

    a_r12_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(is_sw && mode == M_IDLE)) |=> ovf);

    a_r13_conf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_CONF && !is_stop) |=> (mode == M_CONF));

endmodule

bind smb_target_seq smbt_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .mode      (mode),
    .rsp_valid (rsp_valid),
    .ovf       (ovf),
    .dev_quick (dev_quick),
    .dev_send  (dev_send),
    .dev_write (dev_write),
    .dev_recv  (dev_recv),
    .dev_fetch (dev_fetch)
);

// File: tb/test_smb_target_seq.sv
module test_smb_target_seq;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 33;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] op_data = 8'd0;
    logic [5:0] dev_buf_idx = 6'd0;
    logic [7:0] dev_rdata = 8'd0;
    logic [2:0] mode;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       ovf;
    logic       dev_quick, dev_quick_rd, dev_send, dev_write;
    logic [5:0] dev_wr_len;
    logic [7:0] dev_code;
    logic       dev_recv, dev_fetch;
    logic [7:0] dev_fetch_idx;
    logic [7:0] dev_buf_data;

    smb_target_seq i_smb_target_seq (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .dev_buf_idx(dev_buf_idx), .dev_rdata(dev_rdata),
        .mode(mode), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ovf(ovf),
        .dev_quick(dev_quick), .dev_quick_rd(dev_quick_rd), .dev_send(dev_send),
        .dev_write(dev_write), .dev_wr_len(dev_wr_len), .dev_code(dev_code),
        .dev_recv(dev_recv), .dev_fetch(dev_fetch), .dev_fetch_idx(dev_fetch_idx),
        .dev_buf_data(dev_buf_data)
    );

    always #2.5 clk = ~clk;

    localparam logic [2:0] SW = 3'd0, SR = 3'd1, SP = 3'd2, NK = 3'd3, BY = 3'd4, RQ = 3'd5;

    int total = 0;
    int bad = 0;
    int bidx = 0;

    // Reference model state.
    int m_mode = 0;
    int m_cnt = 0;
    int m_idx = 0;
    int m_cmd = 0;
    int m_ovf = 0;
    int m_rv = 0;
    int m_rd = 0;
    byte unsigned m_mem [DEPTH];

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input bit v, input logic [2:0] op,
                        input logic [7:0] d, input logic [7:0] rdat);
        int e_q, e_qr, e_s, e_w, e_len, e_rc, e_f;
        int n_mode, n_cnt, n_idx, n_cmd, n_ovf, n_rv, n_rd;
        int do_push;
        int cur_b;
        @(negedge clk);
        op_valid = v; op_code = op; op_data = d; dev_rdata = rdat;
        cur_b = bidx;
        dev_buf_idx = 6'(bidx);
        bidx = (bidx + 1) % DEPTH;
        e_q = 0; e_qr = 0; e_s = 0; e_w = 0; e_len = 0; e_rc = 0; e_f = 0; do_push = 0;
        n_mode = m_mode; n_cnt = m_cnt; n_idx = m_idx; n_cmd = m_cmd; n_ovf = m_ovf;
        n_rv = 0; n_rd = 0;
        if (v) begin
            case (op)
                SW: if (m_mode == 0) begin n_mode = 1; n_ovf = 0; n_cnt = 0; end
                    else n_mode = 5;
                SR: if (m_mode == 0) n_mode = 2;
                    else if (m_mode == 1) begin
                        if (m_cnt == 0) n_mode = 5;
                        else begin
                            if (m_cnt > 1) begin e_w = 1; e_len = m_cnt - 1; end
                            n_cmd = m_mem[0]; n_cnt = 0; n_idx = 0; n_mode = 3;
                        end
                    end else n_mode = 5;
                SP: begin
                    if (m_mode == 1) begin
                        if (m_cnt == 0) e_q = 1;
                        else if (m_cnt == 1) e_s = 1;
                        else begin e_w = 1; e_len = m_cnt - 1; end
                    end else if (m_mode == 2) begin e_q = 1; e_qr = 1; end
                    n_mode = 0; n_cnt = 0;
                end
                NK: if (m_mode == 3 || m_mode == 4) n_mode = 4; else n_mode = 5;
                BY: if (m_mode == 1) begin
                        if (m_cnt == DEPTH) n_ovf = 1;
                        else begin do_push = 1; n_cnt = m_cnt + 1; end
                    end
                RQ: begin
                    n_rv = 1;
                    if (m_mode == 2) begin e_rc = 1; n_rd = rdat; n_mode = 4; end
                    else if (m_mode == 3) begin e_f = 1; n_rd = rdat; n_idx = (m_idx + 1) % 256; end
                    else begin n_rd = 0; n_mode = 5; end
                end
                default: ;
            endcase
        end
        #1;
        chk(req, "mode", int'(mode), m_mode);
        chk(req, "rsp_valid", int'(rsp_valid), m_rv);
        chk(req, "rsp_data", int'(rsp_data), m_rd);
        chk("R12", "ovf", int'(ovf), m_ovf);
        chk(req, "dev_quick", int'(dev_quick), e_q);
        chk(req, "dev_quick_rd", int'(dev_quick_rd), e_qr);
        chk(req, "dev_send", int'(dev_send), e_s);
        chk(req, "dev_write", int'(dev_write), e_w);
        chk(req, "dev_wr_len", int'(dev_wr_len), e_len);
        chk(req, "dev_recv", int'(dev_recv), e_rc);
        chk(req, "dev_fetch", int'(dev_fetch), e_f);
        chk("R9", "dev_fetch_idx", int'(dev_fetch_idx), m_idx);
        chk(req, "dev_code", int'(dev_code), (e_s || e_w) ? int'(m_mem[0]) : m_cmd);
        chk("R5", "dev_buf_data", int'(dev_buf_data), int'(m_mem[cur_b]));
        @(posedge clk);
        if (do_push) m_mem[m_cnt] = d;
        m_mode = n_mode; m_cnt = n_cnt; m_idx = n_idx; m_cmd = n_cmd;
        m_ovf = n_ovf; m_rv = n_rv; m_rd = n_rd;
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) step(req, 1'b0, SP, 8'h00, 8'h00);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle("R1", 3);
        // R3: quick write
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R3", 1, SP, 8'h00, 8'h00);
        // R4: send byte
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R4", 1, BY, 8'h5A, 8'h00);
        step("R4", 1, SP, 8'h00, 8'h00);
        // R5: command write with two data bytes, then scan the buffer
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R5", 1, BY, 8'h10, 8'h00);
        step("R5", 1, BY, 8'h11, 8'h00);
        step("R5", 1, BY, 8'h22, 8'h00);
        step("R5", 1, SP, 8'h00, 8'h00);
        idle("R5", DEPTH);
        // R6: quick read
        step("R2", 1, SR, 8'h00, 8'h00);
        step("R6", 1, SP, 8'h00, 8'h00);
        // R8: receive byte
        step("R2", 1, SR, 8'h00, 8'h00);
        step("R8", 1, RQ, 8'h00, 8'h77);
        step("R8", 1, SP, 8'h00, 8'h00);
        // R7/R9/R10: read word
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R7", 1, BY, 8'h40, 8'h00);
        step("R7", 1, SR, 8'h00, 8'h00);
        step("R9", 1, RQ, 8'h00, 8'hC1);
        step("R9", 1, RQ, 8'h00, 8'hC2);
        step("R10", 1, NK, 8'h00, 8'h00);
        step("R10", 1, NK, 8'h00, 8'h00);
        step("R6", 1, SP, 8'h00, 8'h00);
        // R7: write dispatched at turnaround
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R7", 1, BY, 8'h41, 8'h00);
        step("R7", 1, BY, 8'h01, 8'h00);
        step("R7", 1, BY, 8'h02, 8'h00);
        step("R7", 1, SR, 8'h00, 8'h00);
        step("R9", 1, RQ, 8'h00, 8'h99);
        step("R10", 1, NK, 8'h00, 8'h00);
        step("R6", 1, SP, 8'h00, 8'h00);
        // R7 error: turnaround with no bytes; R13 confused is sticky
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R7", 1, SR, 8'h00, 8'h00);
        step("R13", 1, BY, 8'h33, 8'h00);
        step("R13", 1, NK, 8'h00, 8'h00);
        step("R13", 1, SW, 8'h00, 8'h00);
        step("R13", 1, RQ, 8'h00, 8'h55);
        step("R13", 1, SP, 8'h00, 8'h00);
        // R10: NACK in idle
        step("R10", 1, NK, 8'h00, 8'h00);
        step("R6", 1, SP, 8'h00, 8'h00);
        // R2: start-send in receive-byte
        step("R2", 1, SR, 8'h00, 8'h00);
        step("R2", 1, SW, 8'h00, 8'h00);
        step("R6", 1, SP, 8'h00, 8'h00);
        // R11: bytes outside write-data ignored
        step("R11", 1, BY, 8'hEE, 8'h00);
        step("R11", 1, SW, 8'h00, 8'h00);
        step("R11", 1, SP, 8'h00, 8'h00);
        step("R11", 1, SR, 8'h00, 8'h00);
        step("R11", 1, BY, 8'hEF, 8'h00);
        step("R11", 1, SP, 8'h00, 8'h00);
        step("R11", 1, 3'd6, 8'h00, 8'h00);
        step("R11", 1, 3'd7, 8'h00, 8'h00);
        // R12: overflow
        step("R2", 1, SW, 8'h00, 8'h00);
        for (int i = 0; i < 36; i++) step("R12", 1, BY, 8'(8'h80 + i), 8'h00);
        step("R12", 1, SP, 8'h00, 8'h00);
        idle("R12", DEPTH);
        step("R12", 1, SW, 8'h00, 8'h00);
        step("R12", 1, SP, 8'h00, 8'h00);
        // R13: unexpected byte requests
        step("R13", 1, RQ, 8'h00, 8'h66);
        step("R13", 1, SP, 8'h00, 8'h00);
        step("R2", 1, SR, 8'h00, 8'h00);
        step("R8", 1, RQ, 8'h00, 8'h12);
        step("R13", 1, RQ, 8'h00, 8'h34);
        step("R13", 1, SP, 8'h00, 8'h00);
        idle("R1", 2);
        summary();
        $finish;
    end

endmodule